// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block is a clocked controller for a classic asynchronous DRAM. A host asks for one read or one write by raising a request while the sequencer is ready. The sequencer then runs the whole access on the memory pins. It first drives the row half of the address and lowers the row strobe. It then switches the pins to the column half and lowers the column strobe. The write-enable, output-enable and data-bus driver are placed around those falling edges in the order that reads and writes each need. The cycle ends by returning both strobes high and holding a precharge gap.

Every setup time, hold time, pulse width and latency is a whole number of clock cycles set by a parameter. A single down-counter times each phase. Read data is captured from the bus at the end of the column-strobe-low phase. It is handed to the host with a one-cycle valid pulse.

Top module: `adram_seq`

## Requirements
- R1: During and after reset, with no request, the row strobe, column strobe, write-enable and output-enable are all high, the data driver is off, `req_ready` is 1 and `rd_valid` is 0.
- R2: After an accepted request, the row field (upper HALF_W address bits) is on `dram_addr` for T_ASR cycles with the row strobe high. The row strobe then falls and the row field stays on the pins for T_RAH more cycles.
- R3: After the row hold, the column field (lower HALF_W address bits) is on `dram_addr` for T_ASC cycles before the column strobe falls. The column field stays on the pins, unchanged, for as long as the column strobe is low.
- R4: In a write, write-enable is low and the data driver is on with the request's write data from the start of column setup to the end of the column-strobe-low phase. That window lasts at least T_WP cycles, and output-enable stays high throughout.
- R5: In a read, write-enable stays high for the whole cycle and the data driver never turns on. Output-enable is low from the second column-strobe-low cycle to the end of that phase.
- R6: The column strobe stays low for max(T_CAH, T_WP−T_ASC) cycles in a write and max(T_CAH, T_RD_LAT) cycles in a read. Read data is sampled at the last clock edge of that phase, so it is captured no earlier than T_RD_LAT cycles after the column strobe falls (T_RD_LAT ≥ 2).
- R7: Each cycle ends with both strobes high for T_RP cycles before `req_ready` returns to 1. The row strobe never falls after fewer than T_RP high cycles.
- R8: A request is taken only while `req_ready` is 1, and the address, direction and data are latched at that edge. Requests and input changes while busy neither alter the running access nor start another one.
- R9: A read raises `rd_valid` for exactly one cycle, the first precharge cycle, with the captured word on `rd_data`. A write never raises `rd_valid`.
- R10: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `req_ready` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Full address, row in upper half, column in lower half |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Captured read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | HALF_W | Multiplexed row/column address |
| dram_dq_in | input | DATA_W | Data bus input from memory |
| dram_dq_out | output | DATA_W | Data bus value to memory |
| dram_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with HALF_W=4 and DATA_W=16, so a 256-word memory model behind the pins covers the whole address space and random read-after-write traffic hits earlier writes often. The timing parameters are T_ASR=2, T_RAH=1, T_ASC=1, T_CAH=2, T_WP=5, T_RD_LAT=3 and T_RP=3. With these values the write column-strobe phase (4 cycles, set by the write pulse width) is longer than the read phase (3 cycles, set by the latency). A wrong choice between the two formulas therefore shifts every later edge and is caught by the per-cycle pin comparison.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ROW_SU   = 3'd1,
    ST_ROW_HOLD = 3'd2,
    ST_COL_SU   = 3'd3,
    ST_CAS_LOW  = 3'd4,
    ST_PRECHG   = 3'd5
  } seq_state_e;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Length of the column-strobe-low phase for each direction.
  function automatic int cas_phase_len(bit is_wr, int t_cah, int t_wp,
                                       int t_asc, int t_rd_lat);
    if (is_wr) return max_of(t_cah, t_wp - t_asc);
    return max_of(t_cah, t_rd_lat);
  endfunction

endpackage

// File: rtl/adram_phase_timer.sv
module adram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/adram_pin_drive.sv
module adram_pin_drive
  import adram_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 16
) (
  input  seq_state_e          state,
  input  logic                is_wr,
  input  logic                cas_first,
  input  logic [2*HALF_W-1:0] addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [HALF_W-1:0]   maddr,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);

  logic [HALF_W-1:0] row_f;
  logic [HALF_W-1:0] col_f;

  assign row_f  = addr[2*HALF_W-1:HALF_W];
  assign col_f  = addr[HALF_W-1:0];
  assign dq_out = wdata;

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    maddr = '0;
    unique case (state)
      ST_ROW_SU: begin
        maddr = row_f;
      end
      ST_ROW_HOLD: begin
        ras_n = 1'b0;
        maddr = row_f;
      end
      ST_COL_SU: begin
        ras_n = 1'b0;
        maddr = col_f;
        we_n  = ~is_wr;
        dq_oe = is_wr;
      end
      ST_CAS_LOW: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        maddr = col_f;
        we_n  = ~is_wr;
        dq_oe = is_wr;
        oe_n  = is_wr | cas_first;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/adram_rd_capture.sv
module adram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture_en;
      if (capture_en) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int DATA_W   = 16,
  parameter int T_ASR    = 2,
  parameter int T_RAH    = 1,
  parameter int T_ASC    = 1,
  parameter int T_CAH    = 2,
  parameter int T_WP     = 3,
  parameter int T_RD_LAT = 3,
  parameter int T_RP     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_wr,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [HALF_W-1:0]   dram_addr,
  input  logic [DATA_W-1:0]   dram_dq_in,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe
);

  localparam int LEN_CAS_WR = cas_phase_len(1'b1, T_CAH, T_WP, T_ASC, T_RD_LAT);
  localparam int LEN_CAS_RD = cas_phase_len(1'b0, T_CAH, T_WP, T_ASC, T_RD_LAT);
  localparam int LEN_MAX    = max_of(max_of(max_of(T_ASR, T_RAH), max_of(T_ASC, T_RP)),
                                     max_of(LEN_CAS_WR, LEN_CAS_RD));
  localparam int CNT_W      = $clog2(LEN_MAX + 1);

  seq_state_e          state, state_nxt;
  logic                lat_wr;
  logic [2*HALF_W-1:0] lat_addr;
  logic [DATA_W-1:0]   lat_wdata;
  logic                cas_first;

  // Named internal events, used by the bound checker.
  logic                accept;
  logic                phase_done;
  logic                capture_en;
  logic                timer_load;
  logic [CNT_W-1:0]    timer_val;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req & req_ready;
  assign capture_en = (state == ST_CAS_LOW) & ~lat_wr & phase_done;

  always_comb begin
    state_nxt  = state;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_nxt  = ST_ROW_SU;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_ASR - 1);
      end
      ST_ROW_SU: if (phase_done) begin
        state_nxt  = ST_ROW_HOLD;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_RAH - 1);
      end
      ST_ROW_HOLD: if (phase_done) begin
        state_nxt  = ST_COL_SU;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_ASC - 1);
      end
      ST_COL_SU: if (phase_done) begin
        state_nxt  = ST_CAS_LOW;
        timer_load = 1'b1;
        timer_val  = lat_wr ? CNT_W'(LEN_CAS_WR - 1) : CNT_W'(LEN_CAS_RD - 1);
      end
      ST_CAS_LOW: if (phase_done) begin
        state_nxt  = ST_PRECHG;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_RP - 1);
      end
      ST_PRECHG: if (phase_done) begin
        state_nxt  = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      cas_first <= 1'b0;
    end else begin
      state     <= state_nxt;
      cas_first <= (state == ST_COL_SU) & phase_done;
      if (accept) begin
        lat_wr    <= req_wr;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
    end
  end

  adram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (phase_done)
  );

  adram_pin_drive #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_pins (
    .state     (state),
    .is_wr     (lat_wr),
    .cas_first (cas_first),
    .addr      (lat_addr),
    .wdata     (lat_wdata),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .maddr     (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe)
  );

  adram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .dq_in      (dram_dq_in),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/adram_seq_checker.sv
module adram_seq_checker #(
  parameter int HALF_W = 8,
  parameter int T_RP   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [HALF_W-1:0] maddr,
  input logic              rd_valid,
  input logic              req_ready,
  input logic              capture_en
);

  localparam int HC_W = $clog2(T_RP + 2);

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_cnt <= HC_W'(T_RP);
    else if (!ras_n)                     hi_cnt <= '0;
    else if (hi_cnt < HC_W'(T_RP))       hi_cnt <= hi_cnt + 1'b1;
  end

  assert_cas_inside_ras_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_cas_window_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !$past(cas_n)) |-> ($stable(we_n) && $stable(maddr)));

  assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !cas_n && !dq_oe));

  assert_drive_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && oe_n));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_capture_bus_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> (!cas_n && !oe_n));

  assert_precharge_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n)) |-> (hi_cnt >= HC_W'(T_RP)));

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && we_n && oe_n && !dq_oe));

endmodule

bind adram_seq adram_seq_checker #(.HALF_W(HALF_W), .T_RP(T_RP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (dram_ras_n),
  .cas_n      (dram_cas_n),
  .we_n       (dram_we_n),
  .oe_n       (dram_oe_n),
  .dq_oe      (dram_dq_oe),
  .maddr      (dram_addr),
  .rd_valid   (rd_valid),
  .req_ready  (req_ready),
  .capture_en (capture_en)
);

// File: tb/adram_seq_bench.sv
module adram_seq_bench;

  localparam int HW  = 4;
  localparam int DW  = 16;
  localparam int AW  = 2 * HW;
  localparam int TA  = 2;  // row setup
  localparam int TB  = 1;  // row hold
  localparam int TC  = 1;  // column setup
  localparam int TCH = 2;
  localparam int TWP = 5;
  localparam int TRL = 3;
  localparam int TP  = 3;
  localparam int DWR = (TCH > TWP - TC) ? TCH : TWP - TC;
  localparam int DRD = (TCH > TRL) ? TCH : TRL;
  localparam int VW  = 6 + HW + 1;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic          ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [HW-1:0] maddr;
  logic [DW-1:0] dq_in, dq_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DW-1:0] mem    [NW];
  logic [DW-1:0] shadow [NW];
  logic [HW-1:0] row_l = '0, col_l = '0;
  logic          prev_ras = 1'b1, prev_cas = 1'b1;

  always #5 clk = ~clk;

  adram_seq #(
    .HALF_W(HW), .DATA_W(DW), .T_ASR(TA), .T_RAH(TB), .T_ASC(TC),
    .T_CAH(TCH), .T_WP(TWP), .T_RD_LAT(TRL), .T_RP(TP)
  ) u_adram_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(maddr), .dram_dq_in(dq_in), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] init_word(int a);
    return DW'(a * 16'h0101) ^ 16'h5A5A;
  endfunction

  // Memory model behind the pins: latches row and column on strobe falls.
  assign dq_in = !oe_n ? mem[{row_l, col_l}] : 16'hDEAD;

  always @(negedge clk) begin
    if (!ras_n && prev_ras) row_l <= maddr;
    if (!cas_n && prev_cas) begin
      col_l <= maddr;
      if (!we_n && dq_oe) mem[{row_l, maddr}] <= dq_out;
    end
    prev_ras <= ras_n;
    prev_cas <= cas_n;
  end

  // Expected pin vector {ready, ras, cas, we, oe, dq_oe, addr, rd_valid}
  // for the k-th cycle after the accepting edge.
  function automatic logic [VW-1:0] exp_vec(int k, bit wr, logic [AW-1:0] a);
    logic rdy = 1'b0, ra = 1'b1, ca = 1'b1, w = 1'b1, o = 1'b1, d = 1'b0, v = 1'b0;
    logic [HW-1:0] ad = '0;
    int e1 = TA;
    int e2 = TA + TB;
    int e3 = e2 + TC;
    int e4 = e3 + (wr ? DWR : DRD);
    if (k <= e1) ad = a[AW-1:HW];
    else if (k <= e2) begin ra = 1'b0; ad = a[AW-1:HW]; end
    else if (k <= e3) begin ra = 1'b0; ad = a[HW-1:0]; w = !wr; d = wr; end
    else if (k <= e4) begin
      ra = 1'b0; ca = 1'b0; ad = a[HW-1:0]; w = !wr; d = wr;
      o = wr || (k == e3 + 1);
    end else begin
      v = !wr && (k == e4 + 1);
      rdy = (k > e4 + TP);
    end
    return {rdy, ra, ca, w, o, d, ad, v};
  endfunction

  function automatic string phase_tag(int k, bit wr);
    int e3 = TA + TB + TC;
    if (k <= TA + TB) return "R2";
    if (k <= e3) return "R3";
    if (k <= e3 + (wr ? DWR : DRD)) return wr ? "R4" : "R5";
    return "R7";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [VW-1:0] got_vec();
    return {req_ready, ras_n, cas_n, we_n, oe_n, dq_oe, maddr, rd_valid};
  endfunction

  // Runs one access from the current negedge; ends at the negedge where
  // the sequencer is ready again.
  task automatic run_txn(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, bit noise);
    int total = TA + TB + TC + (wr ? DWR : DRD) + TP;
    int rd_k  = TA + TB + TC + DRD + 1;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    for (int k = 1; k <= total + 1; k++) begin
      logic [VW-1:0] ev;
      @(negedge clk);
      ev = exp_vec(k, wr, a);
      check(got_vec() === ev, (k == total + 1) ? "R8" : phase_tag(k, wr),
            "pin vector", 64'(got_vec()), 64'(ev));
      check(!(!cas_n && ras_n), "R10", "cas low without ras", 64'({ras_n, cas_n}), 64'h1);
      if (wr && dq_oe)
        check(dq_out === wd, "R4", "write data", 64'(dq_out), 64'(wd));
      if (!wr && k == rd_k)
        check(rd_valid && rd_data === shadow[a], "R9", "read data", 64'(rd_data), 64'(shadow[a]));
      if (!wr && k == rd_k)
        check(rd_valid === 1'b1, "R6", "capture timing", 64'(rd_valid), 64'h1);
      if (k <= total && noise) begin
        req       = 1'($urandom);
        req_wr    = 1'($urandom);
        req_addr  = AW'($urandom);
        req_wdata = DW'($urandom);
      end else begin
        req = 1'b0;
      end
    end
    if (wr) shadow[a] = wd;
  endtask

  task automatic idle_gap(int n);
    req = 1'b0;
    for (int i = 0; i < n; i++) begin
      req_addr = AW'($urandom);
      @(negedge clk);
      check(got_vec() === {1'b1, 5'b11110, {HW{1'b0}}, 1'b0}, "R8", "idle after busy requests",
            64'(got_vec()), 64'({1'b1, 5'b11110, {HW{1'b0}}, 1'b0}));
    end
  endtask

  initial begin
    logic [VW-1:0] idle_v;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      mem[i]    = init_word(i);
      shadow[i] = init_word(i);
    end
    idle_v = {1'b1, 5'b11110, {HW{1'b0}}, 1'b0};
    repeat (3) @(negedge clk);
    check(got_vec() === idle_v, "R1", "in reset", 64'(got_vec()), 64'(idle_v));
    rst_n = 1'b1;
    @(negedge clk);
    check(got_vec() === idle_v, "R1", "after reset", 64'(got_vec()), 64'(idle_v));

    // Directed corners: extreme addresses and data, unwritten location.
    run_txn(1'b0, 8'h3C, '0, 1'b0);
    run_txn(1'b1, 8'h00, 16'hFFFF, 1'b0);
    run_txn(1'b1, 8'hFF, 16'h0000, 1'b0);
    run_txn(1'b0, 8'h00, '0, 1'b0);
    run_txn(1'b0, 8'hFF, '0, 1'b0);
    idle_gap(2);
    run_txn(1'b1, 8'hA5, 16'h1234, 1'b1);
    run_txn(1'b0, 8'hA5, '0, 1'b1);
    idle_gap(3);

    // Random traffic, noise on the host inputs while busy.
    for (int n = 0; n < 250; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      run_txn(1'($urandom), a, DW'($urandom), 1'b1);
      if (($urandom % 4) == 0) idle_gap(1 + int'($urandom % 3));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule